// File: doc/BRIEF.md
# Paced LCD Start-up Command Serializer

The block brings a three-wire serial LCD out of power-up without any help from outside. After reset it holds the panel's active-low reset line low for a set number of cycles. It then walks through a start-up command list held as parameters and sends each entry as a 9-bit frame. A frame is a data/command flag followed by one byte, most significant bit first.

Every bit stays on the data pin for a long, parameter-sized pause, so the transfer can be followed on a probe or an LED. A pause counter counts up until its top bit becomes set, then clears itself and gives a one-cycle done pulse. The serial clock is low when a new bit appears and goes high halfway through the pause. The panel therefore samples on the rising edge.

Chip select is low for the whole of a frame and high for one full bit period between frames. When the last entry has gone out, the block gives a one-cycle completion pulse and stays idle until the next reset.

Top module: `lcd_cmd_pacer`

## Requirements
- R1: While `rst` is high, and in the cycle after any clock edge at which `rst` is high, the outputs are: `lcd_cs_n_o`=1, `lcd_sck_o`=0, `lcd_sda_o`=0, `list_done_o`=0 and `lcd_rst_n_o`=0.
- R2: `lcd_rst_n_o` rises at the RST_HOLD-th clock edge after reset is released. The first frame's chip select falls one cycle later.
- R3: Each frame is 9 bits. Bit 8 is the flag: 0 marks a command, 1 marks data, and it is taken from bit i of CMD_FLAGS for entry i. Bits 7..0 follow, highest first. The flag is the first bit presented.
- R4: Each bit is held on `lcd_sda_o` for exactly T = 2^PAUSE_LOG2 + 1 cycles. This is the time the pause counter needs to count from zero to its top bit, clear, and give its one-cycle done pulse.
- R5: Within a bit period, `lcd_sck_o` is 0 for the first 2^(PAUSE_LOG2-1) - 1 cycles and 1 for the rest of the period. It is 0 whenever no frame is being sent.
- R6: `lcd_cs_n_o` is low for exactly 9·T cycles per frame and high for exactly T cycles between frames. `lcd_sda_o` is 0 while `lcd_cs_n_o` is high.
- R7: Entries are sent in index order. Entry i is the byte CMD_BYTES[8i+7:8i]. The default list sends 0x11 (leave sleep) first and 0x03 (booster on) second, both as commands.
- R8: `list_done_o` is a single-cycle pulse in the cycle right after the final inter-frame gap. After it, chip select stays high and clock and data stay low.
- R9: A synchronous reset asserted in the middle of a frame aborts that frame. The whole sequence, including the LCD reset hold, then restarts from the first entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lcd_sck_o | output | 1 | Serial clock to the panel |
| lcd_sda_o | output | 1 | Serial data to the panel |
| lcd_cs_n_o | output | 1 | Active-low chip select |
| lcd_rst_n_o | output | 1 | Active-low panel reset |
| list_done_o | output | 1 | One-cycle pulse when the list is complete |

## Verification
The bench builds the block with PAUSE_LOG2 = 3 and RST_HOLD = 5. This makes a bit period 9 cycles long, so three complete frames, their gaps, and a mid-frame reset followed by a full restart all fit in a few hundred cycles. The list is extended to three entries: the two default commands and a data byte 0xA5 with its flag set. The run therefore shows both flag values and a payload with alternating bits. The reference model derives every output from the number of cycles since the last reset.

// File: rtl/lcd_pacer_pkg.sv
package lcd_pacer_pkg;

   localparam int FLAG_W  = 1;
   localparam int BYTE_W  = 8;
   localparam int FRAME_W = FLAG_W + BYTE_W;

   typedef enum logic [2:0] {
      ST_HOLD  = 3'd0,
      ST_LOAD  = 3'd1,
      ST_SHIFT = 3'd2,
      ST_GAP   = 3'd3,
      ST_IDLE  = 3'd4
   } pacer_state_e;

endpackage

// File: rtl/pause_timer.sv
module pause_timer #(
   parameter int CNT_LOG2 = 23
) (
   input  logic clk,
   input  logic rst,
   input  logic en_i,
   output logic done_o,
   output logic late_half_o
);
   localparam int CW = CNT_LOG2 + 1;
   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] cnt_q;
   logic          done_q;

   initial assert (CNT_LOG2 >= 2) else $error("pause_timer: CNT_LOG2 must be at least 2");

   always_ff @(posedge clk) begin
      if (rst || !en_i) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (cnt_q[CNT_LOG2]) begin
         cnt_q  <= '0;
         done_q <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + ONE;
         done_q <= 1'b0;
      end
   end

   assign done_o      = done_q;
   assign late_half_o = cnt_q[CNT_LOG2] | cnt_q[CNT_LOG2-1] | done_q;

   // R4: done is one cycle wide and only follows the terminal count
   p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
      done_q |=> !done_q);
   p_done_from_top_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(done_q) |-> $past(cnt_q[CNT_LOG2]));
   // R4: removing the enable clears the counter and forces done low
   p_idle_clear_r4: assert property (@(posedge clk) disable iff (rst)
      !en_i |=> (!done_q && cnt_q == '0));

endmodule

// File: rtl/cmd_list_rom.sv
module cmd_list_rom #(
   parameter int                     NUM_CMDS  = 2,
   parameter int                     IDX_W     = 2,
   parameter logic [NUM_CMDS*8-1:0]  CMD_BYTES = 16'h0311,
   parameter logic [NUM_CMDS-1:0]    CMD_FLAGS = '0
) (
   input  logic [IDX_W-1:0]                    idx_i,
   output logic [lcd_pacer_pkg::FRAME_W-1:0]   frame_o
);
   import lcd_pacer_pkg::*;

   localparam int TBL = 1 << IDX_W;

   logic [FRAME_W-1:0] table_w [TBL];

   initial assert (TBL > NUM_CMDS) else $error("cmd_list_rom: IDX_W too narrow");

   for (genvar i = 0; i < TBL; i++) begin : g_entry
      if (i < NUM_CMDS) begin : g_used
         assign table_w[i] = {CMD_FLAGS[i], CMD_BYTES[i*BYTE_W +: BYTE_W]};
      end else begin : g_pad
         assign table_w[i] = '0;
      end
   end

   assign frame_o = table_w[idx_i];

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
   parameter int FRAME_W = 9
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] data_i,
   input  logic               shift_i,
   output logic               msb_o,
   output logic               last_o
);
   localparam int BC_W = $clog2(FRAME_W);
   localparam logic [BC_W-1:0] LAST = BC_W'(FRAME_W - 1);
   localparam logic [BC_W-1:0] ONE  = BC_W'(1);

   logic [FRAME_W-1:0] sh_q;
   logic [BC_W-1:0]    bc_q;

   initial assert (FRAME_W >= 2) else $error("frame_shifter: FRAME_W must be at least 2");

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q <= '0;
         bc_q <= '0;
      end else if (load_i) begin
         sh_q <= data_i;
         bc_q <= '0;
      end else if (shift_i) begin
         sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
         bc_q <= bc_q + ONE;
      end
   end

   assign msb_o  = sh_q[FRAME_W-1];
   assign last_o = (bc_q == LAST);

   // R3: never shift beyond the ninth bit of a frame
   p_no_overrun_r3: assert property (@(posedge clk) disable iff (rst)
      last_o |-> !shift_i);
   // R3: load and shift never collide
   p_load_xor_shift_r3: assert property (@(posedge clk) disable iff (rst)
      !(load_i && shift_i));

endmodule

// File: rtl/lcd_cmd_pacer.sv
module lcd_cmd_pacer #(
   parameter int                     PAUSE_LOG2 = 23,
   parameter int                     RST_HOLD   = 16,
   parameter int                     NUM_CMDS   = 2,
   parameter logic [NUM_CMDS*8-1:0]  CMD_BYTES  = 16'h0311,
   parameter logic [NUM_CMDS-1:0]    CMD_FLAGS  = '0
) (
   input  logic clk,
   input  logic rst,
   output logic lcd_sck_o,
   output logic lcd_sda_o,
   output logic lcd_cs_n_o,
   output logic lcd_rst_n_o,
   output logic list_done_o
);
   import lcd_pacer_pkg::*;

   localparam int IDX_W  = $clog2(NUM_CMDS + 1);
   localparam int HOLD_W = $clog2(RST_HOLD + 1);
   localparam logic [IDX_W-1:0]  IDX_END   = IDX_W'(NUM_CMDS);
   localparam logic [IDX_W-1:0]  IDX_ONE   = IDX_W'(1);
   localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RST_HOLD - 1);
   localparam logic [HOLD_W-1:0] HOLD_ONE  = HOLD_W'(1);

   initial assert (RST_HOLD >= 1 && NUM_CMDS >= 1 && PAUSE_LOG2 >= 2)
      else $error("lcd_cmd_pacer: parameter out of range");

   pacer_state_e        state_q;
   logic [HOLD_W-1:0]   hold_q;
   logic [IDX_W-1:0]    idx_q;
   logic                cs_n_q;
   logic                rst_n_q;
   logic                done_q;

   logic                tmr_en, tmr_done, tmr_half;
   logic                load_go, shift_go, sh_msb, sh_last;
   logic [FRAME_W-1:0]  rom_frame;

   assign tmr_en   = (state_q == ST_LOAD) || (state_q == ST_SHIFT) || (state_q == ST_GAP);
   assign shift_go = (state_q == ST_SHIFT) && tmr_done && !sh_last;
   assign load_go  = (state_q == ST_LOAD) ||
                     ((state_q == ST_GAP) && tmr_done && (idx_q != IDX_END));

   pause_timer #(.CNT_LOG2(PAUSE_LOG2)) u_timer (
      .clk         (clk),
      .rst         (rst),
      .en_i        (tmr_en),
      .done_o      (tmr_done),
      .late_half_o (tmr_half)
   );

   cmd_list_rom #(
      .NUM_CMDS  (NUM_CMDS),
      .IDX_W     (IDX_W),
      .CMD_BYTES (CMD_BYTES),
      .CMD_FLAGS (CMD_FLAGS)
   ) u_rom (
      .idx_i   (idx_q),
      .frame_o (rom_frame)
   );

   frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk     (clk),
      .rst     (rst),
      .load_i  (load_go),
      .data_i  (rom_frame),
      .shift_i (shift_go),
      .msb_o   (sh_msb),
      .last_o  (sh_last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_HOLD;
         hold_q  <= '0;
         idx_q   <= '0;
         cs_n_q  <= 1'b1;
         rst_n_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_HOLD: begin
               if (hold_q == HOLD_LAST) begin
                  rst_n_q <= 1'b1;
                  state_q <= ST_LOAD;
               end else begin
                  hold_q <= hold_q + HOLD_ONE;
               end
            end
            ST_LOAD: begin
               cs_n_q  <= 1'b0;
               state_q <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (tmr_done && sh_last) begin
                  cs_n_q  <= 1'b1;
                  idx_q   <= idx_q + IDX_ONE;
                  state_q <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (tmr_done) begin
                  if (idx_q == IDX_END) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     cs_n_q  <= 1'b0;
                     state_q <= ST_SHIFT;
                  end
               end
            end
            ST_IDLE: ;
            default: state_q <= ST_HOLD;
         endcase
      end
   end

   assign lcd_cs_n_o  = cs_n_q;
   assign lcd_rst_n_o = rst_n_q;
   assign list_done_o = done_q;
   assign lcd_sck_o   = (state_q == ST_SHIFT) && tmr_half;
   assign lcd_sda_o   = sh_msb && !cs_n_q;

   // R1: reset drives the idle values
   p_reset_values_r1: assert property (@(posedge clk)
      rst |=> (lcd_cs_n_o && !lcd_rst_n_o && !list_done_o && !lcd_sck_o));
   // R2: no frame while the panel is held in reset
   p_frame_after_release_r2: assert property (@(posedge clk) disable iff (rst)
      !lcd_cs_n_o |-> lcd_rst_n_o);
   // R5: clock only toggles inside a frame
   p_sck_in_frame_r5: assert property (@(posedge clk) disable iff (rst)
      lcd_sck_o |-> !lcd_cs_n_o);
   // R6: data quiet when deselected
   p_sda_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      lcd_cs_n_o |-> !lcd_sda_o);
   // R8: completion pulse is one cycle and leaves chip select high
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
      list_done_o |=> (!list_done_o && lcd_cs_n_o));

endmodule

// File: tb/lcd_cmd_pacer_tb.sv
module lcd_cmd_pacer_tb;

   localparam int N    = 3;
   localparam int H    = 5;
   localparam int NUM  = 3;
   localparam logic [NUM*8-1:0] BYTES = 24'hA50311;
   localparam logic [NUM-1:0]   FLAGS = 3'b100;
   localparam int T    = (1 << N) + 1;
   localparam int FP   = 10 * T;
   localparam int LOWC = (1 << (N - 1)) - 1;
   localparam int ENDC = H + 1 + NUM * FP;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sck, sda, cs_n, rst_n, done;

   int c      = 0;
   bit armed  = 1'b0;
   bit second = 1'b0;
   int n_chk  = 0;
   int n_bad  = 0;

   always #2 clk = ~clk;

   lcd_cmd_pacer #(
      .PAUSE_LOG2 (N),
      .RST_HOLD   (H),
      .NUM_CMDS   (NUM),
      .CMD_BYTES  (BYTES),
      .CMD_FLAGS  (FLAGS)
   ) u_dut (
      .clk         (clk),
      .rst         (rst),
      .lcd_sck_o   (sck),
      .lcd_sda_o   (sda),
      .lcd_cs_n_o  (cs_n),
      .lcd_rst_n_o (rst_n),
      .list_done_o (done)
   );

   always @(posedge clk) begin
      if (rst) begin
         c     <= 0;
         armed <= 1'b1;
      end else begin
         c <= c + 1;
      end
   end

   task automatic check(input string req, input logic act, input logic exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s at c=%0d: actual %b expected %b", req, what, c, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (armed) begin
         logic e_sck, e_sda, e_cs, e_rstn, e_done;
         string t_sda, t_sck, t_cs, t_done, t_rstn;
         e_rstn = (c >= H);
         e_cs = 1'b1; e_sck = 1'b0; e_sda = 1'b0; e_done = 1'b0;
         t_sda = "R6"; t_sck = "R5"; t_cs = "R6"; t_done = "R8"; t_rstn = "R2";
         if (c > H) begin
            int d, f, r;
            d = c - (H + 1);
            f = d / FP;
            r = d % FP;
            if (f >= NUM) begin
               e_done = (d == NUM * FP);
               t_cs = "R8";
            end else if (r < 9 * T) begin
               int b, k;
               logic [8:0] w;
               b = r / T;
               k = r % T;
               w = {FLAGS[f], BYTES[f*8 +: 8]};
               e_cs  = 1'b0;
               e_sda = w[8 - b];
               e_sck = (k >= LOWC);
               t_sda = (b == 0) ? "R3" : "R7";
               if (k == 0 || k == T - 1) t_sda = "R4";
            end
         end
         if (c == 0) begin
            t_sda = "R1"; t_sck = "R1"; t_cs = "R1"; t_done = "R1"; t_rstn = "R1";
         end else if (second) begin
            t_sda = "R9"; t_cs = "R9";
         end
         check(t_cs,   cs_n,  e_cs,   "cs_n");
         check(t_sck,  sck,   e_sck,  "sck");
         check(t_sda,  sda,   e_sda,  "sda");
         check(t_rstn, rst_n, e_rstn, "lcd_rst_n");
         check(t_done, done,  e_done, "list_done");
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // first run to mid second frame, then reset inside a frame
      while (c < H + 1 + FP + 23) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      second = 1'b1;
      while (c < ENDC + 20) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule